// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer with Low-Line Override

This block checks that processor software is still running. Software must toggle a watchdog input line at regular intervals. Each change of level, rising or falling, counts as a kick and restarts an internal cycle counter. If the line stays at one level for `TIMEOUT_CYCLES` clock cycles, the active-low watchdog output falls. It stays low until a later kick. The raw input passes through a two-flop synchroniser inside the block. A kick is seen when the two most recent synchronised samples differ.

Three side inputs change this behaviour:
- While the system reset state is active, the counter is held at zero, so timing starts only once reset is released.
- A float flag stands in for detection of a line that has been left undriven. While it is set, timing is switched off, and a change of the flag in either direction restarts the counter.
- A supply-low flag pulls the output low combinationally, whatever the timer state. The output therefore also works as a low-line indicator, and it comes back in the same cycle the flag clears.

The output can drive an interrupt, or be looped to a manual reset, outside this block.

Top module: `wdog_kick_monitor`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter and the synchroniser clear. After reset with `supply_low` low, `wd_out_n` is 1.
- R2: With no kick, no system reset, `wd_float` low and `supply_low` low, `wd_out_n` falls on exactly the `TIMEOUT_CYCLES`-th rising edge after the counter was last cleared.
- R3: A low-to-high change on `wd_in` is a kick. It clears the counter at the third rising edge after the change is applied: two synchroniser edges, then the clearing edge.
- R4: A high-to-low change on `wd_in` is a kick with the same three-edge latency as R3.
- R5: Once timed out, `wd_out_n` stays low until a kick, a system reset or a float-flag change clears the counter. It returns high right after that clearing edge.
- R6: A kick that falls on the edge where the counter would reach `TIMEOUT_CYCLES` takes priority, and `wd_out_n` stays high.
- R7: While `sys_reset` is 1, the counter is held at zero. `wd_out_n` then falls `TIMEOUT_CYCLES` edges after `sys_reset` returns to 0, if no kick arrives.
- R8: While `supply_low` is 1, `wd_out_n` is 0 in the same cycle, whatever the timer state.
- R9: When `supply_low` returns to 0 and the timer has not expired, `wd_out_n` returns to 1 in the same cycle, with no added delay.
- R10: While `wd_float` is 1, timing is disabled and `wd_out_n` equals the inverse of `supply_low`.
- R11: A change of `wd_float` in either direction clears the counter at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| wd_in | input | 1 | Raw watchdog kick line from software |
| wd_float | input | 1 | Line-undriven flag; disables timing |
| supply_low | input | 1 | Supply-below-threshold flag |
| sys_reset | input | 1 | System reset state, active high; holds the timer clear |
| wd_out_n | output | 1 | Active-low watchdog / low-line output |

## Verification
The timer is tried in several ways:
- **No toggling at all.** This measures the exact timeout edge.
- **Rising and falling toggles on their own.** These show that both polarities clear the timer with the same latency.
- **A toggle placed so that its clearing edge coincides with the would-be timeout edge.** This separates a design that gives the kick priority from one that lets the output dip for one cycle.
- **Supply-low and float changes on a running, an expired and a disabled timer.** These separate the combinational override from a registered one, and show whether float changes restart the count.
- **Long random stretches with changing kick rates.** These mix all of the above against a cycle-level reference model.

// File: rtl/wdk_pkg.sv
// Shared helpers for the watchdog kick monitor.
// Assumes TIMEOUT_CYCLES >= 4 so the kick latency is shorter than the timeout.
package wdk_pkg;
    // Counter width able to hold the value TIMEOUT_CYCLES itself.
    function automatic int unsigned cnt_width(input int unsigned timeout);
        return (timeout < 2) ? 1 : $clog2(timeout + 1);
    endfunction
endpackage

// File: rtl/wdk_edge_sync.sv
// Brings the asynchronous kick line into the clock domain through SYNC_STAGES
// flops, then flags a kick when the last two synchronised samples differ.
// Assumes the line is slow compared with clk (a level persists >= 2 cycles).
module wdk_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic kick
);
    localparam int unsigned CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the raw line through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN-2:0], line_async};
    end

    // Either polarity of change is a kick.
    assign kick = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];
endmodule

// File: rtl/wdk_timer.sv
// Idle-cycle counter that saturates at TIMEOUT_CYCLES. Any clear request wins
// over counting, which gives a kick priority on the would-be timeout edge.
// Assumes clear requests are already synchronous to clk.
module wdk_timer #(
    parameter int unsigned TIMEOUT_CYCLES = 200,
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [CW-1:0] count,
    output logic          expired
);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

    logic [CW-1:0] count_q;

    // Clear on request, otherwise count up and hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)       count_q <= '0;
        else if (count_q != LIMIT) count_q <= count_q + 1'b1;
    end

    assign count   = count_q;
    assign expired = (count_q == LIMIT);
endmodule

// File: rtl/wdk_out_ctl.sv
// Builds the active-low output: supply-low forces it low at once, a floating
// line hides the timer, otherwise an expired timer pulls it low.
// Purely combinational so that supply-low changes show in the same cycle.
module wdk_out_ctl (
    input  logic expired,
    input  logic floating,
    input  logic supply_low,
    output logic out_n
);
    // Output merge; the override has no register in its path.
    always_comb begin
        out_n = ~(supply_low | (expired & ~floating));
    end
endmodule

// File: rtl/wdog_kick_monitor.sv
// Top of the watchdog kick monitor. Sync + edge detect feeds the idle counter;
// system reset, the float flag and float-flag changes also clear it.
// Assumes rst_n is synchronous to clk and sys_reset/wd_float/supply_low are
// already synchronous.
module wdog_kick_monitor #(
    parameter int unsigned TIMEOUT_CYCLES = 200,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_in,
    input  logic wd_float,
    input  logic supply_low,
    input  logic sys_reset,
    output logic wd_out_n
);
    localparam int unsigned CW = wdk_pkg::cnt_width(TIMEOUT_CYCLES);

    logic          kick;
    logic          float_q;
    logic          float_chg;
    logic          tmr_clear;
    logic [CW-1:0] tmo_cnt;
    logic          tmo_hit;

    wdk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (wd_in),
        .kick       (kick)
    );

    // Remember the float flag to spot entry to and exit from floating.
    always_ff @(posedge clk) begin
        if (!rst_n) float_q <= 1'b0;
        else        float_q <= wd_float;
    end

    assign float_chg = float_q ^ wd_float;
    assign tmr_clear = sys_reset | kick | float_chg | wd_float;

    wdk_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .count   (tmo_cnt),
        .expired (tmo_hit)
    );

    wdk_out_ctl u_out (
        .expired    (tmo_hit),
        .floating   (wd_float),
        .supply_low (supply_low),
        .out_n      (wd_out_n)
    );
endmodule

// File: rtl/wdog_kick_monitor_chk.sv
// Property checker for wdog_kick_monitor, attached by bind below.
module wdog_kick_monitor_chk #(
    parameter int unsigned TIMEOUT_CYCLES = 200,
    parameter int unsigned CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wd_float,
    input logic          supply_low,
    input logic          sys_reset,
    input logic          wd_out_n,
    input logic          kick,
    input logic          float_chg,
    input logic [CW-1:0] tmo_cnt
);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

    assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_cnt <= LIMIT);

    assert_low_means_expired_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_out_n && !supply_low) |-> (tmo_cnt == LIMIT && !wd_float));

    assert_expired_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_cnt == LIMIT && !kick && !sys_reset && !float_chg && !wd_float)
        |=> (tmo_cnt == LIMIT));

    assert_sysrst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |=> (tmo_cnt == '0));

    assert_kick_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (tmo_cnt == '0));

    assert_supply_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> !wd_out_n);

    assert_float_lowline_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wd_float |-> (wd_out_n == !supply_low));
endmodule

bind wdog_kick_monitor wdog_kick_monitor_chk #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wd_float   (wd_float),
    .supply_low (supply_low),
    .sys_reset  (sys_reset),
    .wd_out_n   (wd_out_n),
    .kick       (kick),
    .float_chg  (float_chg),
    .tmo_cnt    (tmo_cnt)
);

// File: tb/wdog_kick_monitor_tb.sv
module wdog_kick_monitor_tb;
    localparam int T = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wd_in = 1'b0;
    logic wd_float = 1'b0;
    logic supply_low = 1'b0;
    logic sys_reset = 1'b0;
    logic wd_out_n;

    int total = 0;
    int bad = 0;

    // Reference model state, built from the requirements.
    int   mc = 0;
    logic m1 = 0, m2 = 0, m3 = 0, mfl = 0;

    always #4 clk = ~clk;

    wdog_kick_monitor #(.TIMEOUT_CYCLES(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .wd_in(wd_in), .wd_float(wd_float),
        .supply_low(supply_low), .sys_reset(sys_reset), .wd_out_n(wd_out_n)
    );

    // Model: R3/R4 kick after two sync stages, R7/R10/R11 clears, R2 saturating count.
    always @(posedge clk) begin
        logic kk, fc;
        kk = m2 ^ m3;
        fc = mfl ^ wd_float;
        if (!rst_n) begin
            mc = 0; m1 = 0; m2 = 0; m3 = 0; mfl = 0;
        end else begin
            if (sys_reset || kk || fc || wd_float) mc = 0;
            else if (mc < T) mc = mc + 1;
            m3 = m2; m2 = m1; m1 = wd_in; mfl = wd_float;
        end
    end

    function automatic logic exp_out();
        return !(supply_low || (!wd_float && mc == T));
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: wd_out_n=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one cycle, then compare against the model off the edge.
    task automatic step(input string tag);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(tag, wd_out_n, exp_out());
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: run hung");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int rate;
        void'($urandom(32'd20240611));

        // R1: reset state
        steps(3, "R1");
        chk("R1", wd_out_n, 1'b1);
        @(negedge clk); rst_n = 1'b1;

        // R2: exact timeout edge after system reset release
        sys_reset = 1'b1; step("R7");
        sys_reset = 1'b0;
        n = 0;
        while (wd_out_n && n < 200) begin step("R2"); n++; end
        total++;
        if (n != T) begin bad++; $display("FAIL R2: timeout edges=%0d expected=%0d", n, T); end

        // R5: stays low without a kick
        steps(10, "R5");
        chk("R5", wd_out_n, 1'b0);

        // R3: rising change clears, high after the third edge
        wd_in = 1'b1; steps(2, "R3");
        chk("R3", wd_out_n, 1'b0);
        step("R3");
        chk("R3", wd_out_n, 1'b1);

        // R4: falling change clears after timing out again
        steps(T, "R2");
        chk("R2", wd_out_n, 1'b0);
        wd_in = 1'b0; steps(3, "R4");
        chk("R4", wd_out_n, 1'b1);

        // R6: kick clearing edge lands on the would-be timeout edge
        steps(T - 3, "R6");
        wd_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step("R6");
            chk("R6", wd_out_n, 1'b1);
        end

        // R8/R9: supply-low overrides immediately and releases immediately
        @(negedge clk); supply_low = 1'b1; #1;
        chk("R8", wd_out_n, 1'b0);
        steps(3, "R8");
        @(negedge clk); supply_low = 1'b0; #1;
        chk("R9", wd_out_n, 1'b1);
        steps(T, "R8");
        @(negedge clk); supply_low = 1'b1; #1;
        chk("R8", wd_out_n, 1'b0);
        @(negedge clk); supply_low = 1'b0; #1;
        chk("R5", wd_out_n, 1'b0);

        // R10: floating line disables timing, output tracks supply only
        wd_float = 1'b1;
        steps(2 * T, "R10");
        chk("R10", wd_out_n, 1'b1);
        @(negedge clk); supply_low = 1'b1; #1;
        chk("R10", wd_out_n, 1'b0);
        @(negedge clk); supply_low = 1'b0; #1;
        chk("R10", wd_out_n, 1'b1);

        // R11: leaving float restarts the count from zero
        @(negedge clk); wd_float = 1'b0;
        steps(T, "R11");
        chk("R11", wd_out_n, 1'b1);
        step("R11");
        chk("R11", wd_out_n, 1'b0);

        // R11: entering float near the limit restarts the count too
        wd_in = 1'b0; steps(3, "R11");
        steps(T - 5, "R11");
        @(negedge clk); wd_float = 1'b1;
        steps(2, "R11");
        @(negedge clk); wd_float = 1'b0;
        steps(T - 1, "R11");
        chk("R11", wd_out_n, 1'b1);

        // R7: held system reset keeps the timer clear
        @(negedge clk); sys_reset = 1'b1;
        steps(2 * T, "R7");
        chk("R7", wd_out_n, 1'b1);
        @(negedge clk); sys_reset = 1'b0;
        steps(T - 1, "R7");
        chk("R7", wd_out_n, 1'b1);
        step("R7");
        chk("R7", wd_out_n, 0);

        // Random phases with changing kick rates
        for (int ph = 0; ph < 30; ph++) begin
            case ($urandom % 3)
                0: rate = 8;
                1: rate = 35;
                default: rate = 0;
            endcase
            for (int c = 0; c < 120; c++) begin
                @(negedge clk);
                if (rate != 0 && ($urandom % rate) == 0) wd_in = ~wd_in;
                if (($urandom % 150) == 0) wd_float = ~wd_float;
                if (($urandom % 100) == 0) supply_low = ~supply_low;
                sys_reset = (($urandom % 300) == 0);
                #1;
                if (supply_low) chk("R8", wd_out_n, exp_out());
                else if (wd_float) chk("R10", wd_out_n, exp_out());
                else chk("R2", wd_out_n, exp_out());
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule